// File: doc/BRIEF.md
# Three-Phase Triangle Wave Synthesizer

This block turns filtered phase-error strobes into three triangle waveforms spaced a third of a period apart, each delivered as a single-bit pulse-density stream. An oscillator control stage consumes the streams directly, so no digital-to-analog converter is needed. A strobe marked valid moves a shared phase counter one step up or down. With no valid strobe the counter holds. A held counter gives triangles of zero frequency, which means the loop is in lock. The direction of counting sets whether each wave leads or lags its neighbours, and the oscillator reads that as the sign of its correction.

The phase counter is 7 bits wide but has 96 states. Each phase maps its own shifted copy of the counter onto a rising-then-falling amplitude with 48 levels (0 to 47). A first-order accumulator modulator then renders that amplitude as a bit stream whose density of ones is the amplitude divided by 47. Continuous stepping at a 15.625 MHz converter rate gives a top triangle frequency near 162.76 kHz. The counter, the three amplitude mappings and the three modulators all share one clock and one synchronous reset.

Top module: `tri_pdm_synth`

## Requirements
- R1: While `rst` is high at a rising edge, the counter goes to 0, every modulator accumulator clears and `pdm_out` goes to 0. Strobes applied during reset are ignored.
- R2: A rising edge with `err_valid`=1 and `err_up`=1 increments `phase_cnt` by one. The step from 95 goes to 0.
- R3: A rising edge with `err_valid`=1 and `err_up`=0 decrements `phase_cnt` by one. The step from 0 goes to 95.
- R4: A rising edge with `err_valid`=0 leaves `phase_cnt` unchanged, whatever the value of `err_up`.
- R5: Phase A amplitude, `tri_amp[5:0]`, equals c when the count c is below 48, and 95-c otherwise. It follows `phase_cnt` in the same cycle.
- R6: Phase B, `tri_amp[11:6]`, and phase C, `tri_amp[17:12]`, apply the same mapping to (c+32) mod 96 and (c+64) mod 96.
- R7: `pdm_out[p]` is the registered output of phase p's modulator and reflects the amplitude present before that edge. In any 47 consecutive cycles during which a phase's amplitude A stays constant, that bit is 1 in exactly A cycles. Bit 0 is phase A, bit 1 is B and bit 2 is C.
- R8: An amplitude of 47 yields a 1 on every following edge. An amplitude of 0 yields a 0 on every following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Phase-error strobe is valid this cycle |
| err_up | input | 1 | Direction of a valid strobe: 1 counts up, 0 counts down |
| phase_cnt | output | 7 | Modulo-96 phase counter |
| tri_amp | output | 18 | Three 6-bit triangle amplitudes: A in [5:0], B in [11:6], C in [17:12] |
| pdm_out | output | 3 | Pulse-density bits: A in bit 0, B in bit 1, C in bit 2 |

## Verification
A strobe changes `phase_cnt` at the first rising edge after it is applied, and the three amplitudes follow in the same cycle because they are combinational. The bench therefore drives each strobe just after a falling edge and compares the count and all three amplitudes at the next falling edge. Modulator bits trail the amplitude by one more edge. Each density window starts only after the counter has been held for one edge, and then counts ones over the next 47 falling-edge samples. Reset is checked at the first falling edge after the reset edge.

// File: rtl/tri_pdm_pkg.sv
package tri_pdm_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   function automatic step_e decode_step(input logic valid, input logic up);
      if (!valid)  return STEP_HOLD;
      else if (up) return STEP_UP;
      else         return STEP_DOWN;
   endfunction

endpackage

// File: rtl/phase_ctr.sv
module phase_ctr
   import tri_pdm_pkg::*;
#(
   parameter int MOD = 96,
   parameter int CW  = $clog2(MOD)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_valid,
   input  logic          step_up,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] TOP = CW'(MOD - 1);

   initial begin : g_param_chk
      assert (MOD >= 2) else $error("phase_ctr: MOD must be at least 2");
      assert ((1 << CW) >= MOD) else $error("phase_ctr: CW too narrow for MOD");
   end

   step_e         cmd;
   logic [CW-1:0] inc_v;
   logic [CW-1:0] dec_v;

   always_comb cmd = decode_step(step_valid, step_up);

   generate
      if (MOD == (1 << CW)) begin : g_pow2_wrap
         always_comb begin
            inc_v = cnt + 1'b1;
            dec_v = cnt - 1'b1;
         end
      end else begin : g_cmp_wrap
         always_comb begin
            inc_v = (cnt == TOP)   ? '0  : cnt + 1'b1;
            dec_v = (cnt == '0)    ? TOP : cnt - 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         unique case (cmd)
            STEP_UP:   cnt <= inc_v;
            STEP_DOWN: cnt <= dec_v;
            default:   cnt <= cnt;
         endcase
      end
   end

   // R1: the count never leaves the modulo range
   p_in_range_r1: assert property (@(posedge clk) disable iff (rst)
      cnt <= TOP);

   // R2: an up strobe advances by one, wrapping at the top
   p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
      (step_valid && step_up) |=>
         (cnt == (($past(cnt) == TOP) ? '0 : CW'($past(cnt) + 1'b1))));

   // R3: a down strobe retreats by one, wrapping at zero
   p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
      (step_valid && !step_up) |=>
         (cnt == (($past(cnt) == '0) ? TOP : CW'($past(cnt) - 1'b1))));

   // R4: no strobe, no movement
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !step_valid |=> $stable(cnt));

endmodule

// File: rtl/tri_map.sv
module tri_map #(
   parameter int MOD    = 96,
   parameter int CW     = $clog2(MOD),
   parameter int AW     = $clog2(MOD / 2),
   parameter int OFFSET = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt,
   output logic [AW-1:0] amp
);

   localparam int          HALF    = MOD / 2;
   localparam logic [CW:0] MOD_W   = (CW + 1)'(MOD);
   localparam logic [CW:0] HALF_W  = (CW + 1)'(HALF);
   localparam logic [CW:0] TOP_W   = (CW + 1)'(MOD - 1);
   localparam logic [CW:0] OFS_W   = (CW + 1)'(OFFSET % MOD);

   initial begin : g_param_chk
      assert (MOD % 2 == 0) else $error("tri_map: MOD must be even");
      assert ((1 << AW) >= HALF) else $error("tri_map: AW too narrow");
   end

   logic [CW:0] sum_w;
   logic [CW:0] shifted;
   logic [CW:0] folded;

   always_comb begin
      sum_w   = {1'b0, cnt} + OFS_W;
      shifted = (sum_w >= MOD_W) ? (sum_w - MOD_W) : sum_w;
      folded  = (shifted < HALF_W) ? shifted : (TOP_W - shifted);
      amp     = folded[AW-1:0];
   end

   // R5/R6: a unit step of the counter moves the amplitude by at most one level
   p_unit_slope_r5: assert property (@(posedge clk) disable iff (rst)
      (cnt != $past(cnt)) |->
         (((amp >= $past(amp)) ? (amp - $past(amp)) : ($past(amp) - amp)) <= AW'(1)));

   // R6: amplitude stays within the half-period range
   p_amp_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
      amp <= AW'(HALF - 1));

endmodule

// File: rtl/pdm_mod.sv
module pdm_mod #(
   parameter int AW      = 6,
   parameter int AMP_MAX = 47
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] amp,
   output logic          bit_o
);

   localparam int          SW   = $clog2(2 * AMP_MAX + 1);
   localparam logic [SW-1:0] THR = SW'(AMP_MAX);

   initial begin : g_param_chk
      assert (AMP_MAX >= 1) else $error("pdm_mod: AMP_MAX must be positive");
      assert ((1 << AW) > AMP_MAX) else $error("pdm_mod: AW too narrow");
   end

   logic [SW-1:0] acc;
   logic [SW-1:0] sum;
   logic          fire;

   always_comb begin
      sum  = acc + SW'(amp);
      fire = (sum >= THR);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc   <= '0;
         bit_o <= 1'b0;
      end else begin
         acc   <= fire ? (sum - THR) : sum;
         bit_o <= fire;
      end
   end

   // R7: the residue always stays below the threshold
   p_acc_bound_r7: assert property (@(posedge clk) disable iff (rst)
      acc < THR);

   // R8: full-scale amplitude always fires on the next edge
   p_full_fire_r8: assert property (@(posedge clk) disable iff (rst)
      (amp == AW'(AMP_MAX)) |=> bit_o);

   // R8: zero amplitude never fires on the next edge
   p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (amp == '0) |=> !bit_o);

endmodule

// File: rtl/tri_pdm_synth.sv
module tri_pdm_synth #(
   parameter int MOD = 96,
   parameter int NPH = 3,
   parameter int CW  = $clog2(MOD),
   parameter int AW  = $clog2(MOD / 2)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              err_valid,
   input  logic              err_up,
   output logic [CW-1:0]     phase_cnt,
   output logic [NPH*AW-1:0] tri_amp,
   output logic [NPH-1:0]    pdm_out
);

   localparam int AMP_MAX = MOD / 2 - 1;
   localparam int PH_OFS  = MOD / NPH;

   initial begin : g_param_chk
      assert (NPH >= 1) else $error("tri_pdm_synth: NPH must be positive");
      assert (MOD % NPH == 0) else $error("tri_pdm_synth: MOD must split evenly into NPH phases");
      assert (MOD % 2 == 0) else $error("tri_pdm_synth: MOD must be even");
   end

   phase_ctr #(
      .MOD (MOD),
      .CW  (CW)
   ) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .step_valid (err_valid),
      .step_up    (err_up),
      .cnt        (phase_cnt)
   );

   generate
      for (genvar p = 0; p < NPH; p++) begin : g_phase
         logic [AW-1:0] amp_p;

         tri_map #(
            .MOD    (MOD),
            .CW     (CW),
            .AW     (AW),
            .OFFSET (p * PH_OFS)
         ) u_map (
            .clk (clk),
            .rst (rst),
            .cnt (phase_cnt),
            .amp (amp_p)
         );

         pdm_mod #(
            .AW      (AW),
            .AMP_MAX (AMP_MAX)
         ) u_pdm (
            .clk   (clk),
            .rst   (rst),
            .amp   (amp_p),
            .bit_o (pdm_out[p])
         );

         assign tri_amp[p*AW +: AW] = amp_p;
      end
   endgenerate

   // R1: the edge after reset leaves every modulator bit low
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (pdm_out == '0) && (phase_cnt == '0));

endmodule

// File: tb/tri_pdm_synth_bench.sv
module tri_pdm_synth_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        err_valid = 1'b0;
   logic        err_up = 1'b0;
   logic [6:0]  phase_cnt;
   logic [17:0] tri_amp;
   logic [2:0]  pdm_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   tri_pdm_synth u_tri_pdm_synth (
      .clk       (clk),
      .rst       (rst),
      .err_valid (err_valid),
      .err_up    (err_up),
      .phase_cnt (phase_cnt),
      .tri_amp   (tri_amp),
      .pdm_out   (pdm_out)
   );

   // {valid, up, expected count}, walked from count 0
   localparam logic [8:0] VEC [10] = '{
      {1'b1, 1'b0, 7'd95},
      {1'b1, 1'b1, 7'd0},
      {1'b1, 1'b1, 7'd1},
      {1'b0, 1'b1, 7'd1},
      {1'b0, 1'b0, 7'd1},
      {1'b1, 1'b1, 7'd2},
      {1'b1, 1'b0, 7'd1},
      {1'b1, 1'b0, 7'd0},
      {1'b1, 1'b0, 7'd95},
      {1'b1, 1'b0, 7'd94}
   };

   function automatic int tri_f(input int c);
      int m;
      m = c % 96;
      return (m < 48) ? m : 95 - m;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic u);
      err_valid = v;
      err_up    = u;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_amps(input int c);
      chk("R5 phase A amplitude", int'(tri_amp[5:0]),   tri_f(c));
      chk("R6 phase B amplitude", int'(tri_amp[11:6]),  tri_f(c + 32));
      chk("R6 phase C amplitude", int'(tri_amp[17:12]), tri_f(c + 64));
   endtask

   task automatic pdm_window(input int c);
      int ones [3];
      ones = '{0, 0, 0};
      err_valid = 1'b0;
      for (int i = 0; i < 47; i++) begin
         @(negedge clk);
         for (int p = 0; p < 3; p++) ones[p] += int'(pdm_out[p]);
      end
      for (int p = 0; p < 3; p++)
         chk("R7 ones in 47-cycle window", ones[p], tri_f(c + 32 * p));
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int cnt_now;
      @(negedge clk);
      err_valid = 1'b1;
      err_up    = 1'b1;
      repeat (4) @(negedge clk);
      // R1: strobes during reset are ignored, state cleared
      chk("R1 count after reset", int'(phase_cnt), 0);
      chk("R1 pdm after reset", int'(pdm_out), 0);
      rst = 1'b0;
      err_valid = 1'b0;
      chk_amps(0);

      // table walk: R2, R3, R4 wrap and hold cases
      foreach (VEC[i]) begin
         step(VEC[i][8], VEC[i][7]);
         chk(VEC[i][8] ? (VEC[i][7] ? "R2 up step" : "R3 down step") : "R4 hold",
             int'(phase_cnt), int'(VEC[i][6:0]));
         chk_amps(int'(VEC[i][6:0]));
      end
      cnt_now = 94;

      // walk down to 47: phase A at full scale
      repeat (47) step(1'b1, 1'b0);
      cnt_now = 47;
      chk("R3 long descent", int'(phase_cnt), cnt_now);
      chk_amps(cnt_now);
      pdm_window(cnt_now);

      // R8: full scale gives a 1 on every edge
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R8 full-scale bit", int'(pdm_out[0]), 1);
      end

      // R2: a full revolution of up steps returns to the start
      repeat (96) step(1'b1, 1'b1);
      chk("R2 full revolution", int'(phase_cnt), cnt_now);

      // R4: hold with direction toggling
      for (int i = 0; i < 6; i++) step(1'b0, i[0]);
      chk("R4 hold with toggling direction", int'(phase_cnt), cnt_now);

      // mid-run reset while strobing
      rst = 1'b1;
      err_valid = 1'b1;
      err_up = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 count after mid-run reset", int'(phase_cnt), 0);
      chk("R1 pdm after mid-run reset", int'(pdm_out), 0);
      rst = 1'b0;
      err_valid = 1'b0;
      cnt_now = 0;
      chk_amps(cnt_now);
      pdm_window(cnt_now);

      // R8: zero amplitude never fires
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R8 zero-scale bit", int'(pdm_out[0]), 0);
      end

      // another density point after single up steps
      repeat (20) step(1'b1, 1'b1);
      cnt_now = 20;
      chk_amps(cnt_now);
      pdm_window(cnt_now);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule